// File: doc/BRIEF.md
# Per-Counter User Access Gate

This block holds a 64-bit privileged control word with one enable flag for each performance counter. Each event counter, the cycle counter and the fixed-function counter has its own flag. When software at the least-privileged level (level 0) tries to reach a counter, the block decides from these flags whether the access goes through. If it does not, a read returns zero and a write is dropped.

The flags take effect only while the effective user-enable qualifier is high. When the qualifier is low, the flags are ignored and the decision is left to other logic.

The control word is written and read through a plain privileged port. The port tags each access with the privilege level of the requester. An access tagged level 0 is flagged as undefined and has no effect.

User requests carry a valid strobe and are always accepted, so there is no back-pressure. The pass decision and the forwarded write appear in the same cycle as the request. The gated read response appears on the following clock edge with its own valid strobe.

Top module: `pmc_user_gate`

## Requirements
- R1: After reset every implemented enable flag is 0, so a privileged read returns 0.
- R2: A privileged write at level 1, 2 or 3 stores the implemented flags, which a privileged read returns in the same cycle as the read strobe. Bits 63..33 and the flags of unimplemented event counters always read 0.
- R3: With the qualifier at 1 and the selected counter's flag at 0, the pass output is 0, no write is forwarded and the read response is 0.
- R4: With the qualifier at 1 and the flag at 1, the pass output is 1, a write is forwarded with its data, and the read response equals the counter's read data.
- R5: With the qualifier at 0, every implemented counter passes whatever its flag holds.
- R6: A privileged read or write tagged level 0 raises the undefined output, leaves the stored flags unchanged and reads 0.
- R7: A selector naming an event counter at or above NUM_EVT, or any value above 32, is always suppressed, whatever the qualifier holds.
- R8: The pass output is combinational on the request. The response valid and response data are registered and appear one clock after the request.
- R9: Selector values 0..30 name event counters and use flag bits 0..30. Selector 31 is the cycle counter and uses flag bit 31. Selector 32 is the fixed-function counter and uses flag bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_lvl | input | 2 | Privilege level of the control-word access |
| priv_wr | input | 1 | Control-word write strobe |
| priv_rd | input | 1 | Control-word read strobe |
| priv_wdata | input | 64 | Control-word write data |
| priv_rdata | output | 64 | Control-word read data (0 when not reading) |
| priv_undef | output | 1 | Access from level 0 is undefined |
| user_qual | input | 1 | Effective user-enable qualifier |
| usr_valid | input | 1 | User counter access request valid |
| usr_sel | input | 6 | Counter selector (see R9) |
| usr_write | input | 1 | 1 = write, 0 = read |
| usr_wdata | input | 64 | User write data |
| cnt_rdata | input | 64 | Read value of the selected counter |
| usr_pass | output | 1 | Access allowed through |
| fwd_wr | output | 1 | Write forwarded to the counter |
| fwd_wdata | output | 64 | Forwarded write data (0 when not forwarding) |
| rsp_valid | output | 1 | Registered response valid |
| rsp_rdata | output | 64 | Registered gated read data |

## Verification
The bench is built with NUM_EVT set to 24, so some event counters are unimplemented. User requests are applied to a denied event counter, an allowed event counter, the cycle counter and the fixed-function counter, each with the qualifier both high and low. These patterns separate a flag lookup at the wrong bit from a qualifier that is ignored or inverted. Selectors 25 and 40 confirm that unimplemented or nonexistent counters stay blocked even with the qualifier low. Privileged writes of all ones and of sparse patterns at each level show the masking of reserved and unimplemented bits. They also show that writes tagged level 0 are refused.

// File: rtl/pmc_gate_pkg.sv
package pmc_gate_pkg;
  localparam int WORD_W  = 64;
  localparam int SEL_W   = 6;
  localparam int CYC_IDX = 31;
  localparam int FIX_IDX = 32;
  localparam int TOP_IDX = FIX_IDX;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [1:0]        lvl_t;
  localparam lvl_t LVL_USER = 2'd0;
endpackage

// File: rtl/pmc_enable_reg.sv
module pmc_enable_reg
  import pmc_gate_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input  logic  clk,
  input  logic  rst_n,
  input  lvl_t  lvl,
  input  logic  wr,
  input  logic  rd,
  input  word_t wdata,
  output word_t rdata,
  output logic  undef,
  output word_t flags
);
  logic priv_ok;
  assign priv_ok = (lvl != LVL_USER);
  assign undef   = (wr || rd) && !priv_ok;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i < NUM_EVT || i == CYC_IDX || i == FIX_IDX) begin : g_impl
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              q <= 1'b0;
        else if (wr && priv_ok)  q <= wdata[i];
      end
      assign flags[i] = q;
    end else begin : g_zero
      assign flags[i] = 1'b0;
    end
  end

  assign rdata = (rd && priv_ok) ? flags : '0;

  AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !priv_ok) |=> $stable(flags)); // R6
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[WORD_W-1:TOP_IDX+1] == '0); // R2
endmodule

// File: rtl/pmc_access_gate.sv
module pmc_access_gate
  import pmc_gate_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input  word_t flags,
  input  logic  qual,
  input  logic  valid,
  input  sel_t  sel,
  input  logic  write,
  input  word_t wdata,
  output logic  pass,
  output logic  fwd_wr,
  output word_t fwd_wdata
);
  localparam sel_t NEVT_S = sel_t'(NUM_EVT);
  localparam sel_t CYC_S  = sel_t'(CYC_IDX);
  localparam sel_t FIX_S  = sel_t'(FIX_IDX);

  logic present;
  logic flag_bit;

  assign present   = (sel < NEVT_S) || (sel == CYC_S) || (sel == FIX_S);
  assign flag_bit  = flags[sel];
  assign pass      = valid && present && (!qual || flag_bit);
  assign fwd_wr    = pass && write;
  assign fwd_wdata = fwd_wr ? wdata : '0;

  always_comb begin
    if (valid && !present) AST_ABSENT_BLOCKED: assert (!pass); // R7
    if (fwd_wr) AST_FWD_NEEDS_PASS: assert (pass); // R3
  end
endmodule

// File: rtl/pmc_rsp_stage.sv
module pmc_rsp_stage
  import pmc_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  valid,
  input  logic  write,
  input  logic  pass,
  input  word_t cnt_rdata,
  output logic  rsp_valid,
  output word_t rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid;
      rsp_rdata <= (valid && !write && pass) ? cnt_rdata : '0;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> rsp_valid); // R8
  AST_SUPPRESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pass) |=> (rsp_rdata == '0)); // R3
endmodule

// File: rtl/pmc_user_gate.sv
module pmc_user_gate
  import pmc_gate_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  priv_lvl,
  input  logic        priv_wr,
  input  logic        priv_rd,
  input  logic [63:0] priv_wdata,
  output logic [63:0] priv_rdata,
  output logic        priv_undef,
  input  logic        user_qual,
  input  logic        usr_valid,
  input  logic [5:0]  usr_sel,
  input  logic        usr_write,
  input  logic [63:0] usr_wdata,
  input  logic [63:0] cnt_rdata,
  output logic        usr_pass,
  output logic        fwd_wr,
  output logic [63:0] fwd_wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata
);
  word_t flags;

  pmc_enable_reg #(.NUM_EVT(NUM_EVT)) u_reg (
    .clk(clk), .rst_n(rst_n), .lvl(priv_lvl), .wr(priv_wr), .rd(priv_rd),
    .wdata(priv_wdata), .rdata(priv_rdata), .undef(priv_undef), .flags(flags)
  );

  pmc_access_gate #(.NUM_EVT(NUM_EVT)) u_gate (
    .flags(flags), .qual(user_qual), .valid(usr_valid), .sel(usr_sel),
    .write(usr_write), .wdata(usr_wdata), .pass(usr_pass),
    .fwd_wr(fwd_wr), .fwd_wdata(fwd_wdata)
  );

  pmc_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .valid(usr_valid), .write(usr_write),
    .pass(usr_pass), .cnt_rdata(cnt_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  AST_QUAL_LOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_valid && !user_qual && (usr_sel == 6'd31 || usr_sel == 6'd32)) |-> usr_pass); // R5
endmodule

// File: tb/pmc_user_gate_test.sv
module pmc_user_gate_test;
  localparam int NEVT = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv_lvl = 2'd1;
  logic        priv_wr = 1'b0, priv_rd = 1'b0;
  logic [63:0] priv_wdata = '0;
  logic [63:0] priv_rdata;
  logic        priv_undef;
  logic        user_qual = 1'b1;
  logic        usr_valid = 1'b0;
  logic [5:0]  usr_sel = '0;
  logic        usr_write = 1'b0;
  logic [63:0] usr_wdata = '0, cnt_rdata = '0;
  logic        usr_pass, fwd_wr, rsp_valid;
  logic [63:0] fwd_wdata, rsp_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmc_user_gate #(.NUM_EVT(NEVT)) uut (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .priv_wr(priv_wr),
    .priv_rd(priv_rd), .priv_wdata(priv_wdata), .priv_rdata(priv_rdata),
    .priv_undef(priv_undef), .user_qual(user_qual), .usr_valid(usr_valid),
    .usr_sel(usr_sel), .usr_write(usr_write), .usr_wdata(usr_wdata),
    .cnt_rdata(cnt_rdata), .usr_pass(usr_pass), .fwd_wr(fwd_wr),
    .fwd_wdata(fwd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pwrite(logic [1:0] lvl, logic [63:0] d);
    priv_lvl = lvl; priv_wdata = d; priv_wr = 1'b1;
    #1 chk("R6 undef on write", 64'(priv_undef), 64'(lvl == 2'd0));
    @(negedge clk);
    priv_wr = 1'b0;
  endtask

  task automatic pread(logic [1:0] lvl, logic [63:0] exp, string tag);
    priv_lvl = lvl; priv_rd = 1'b1;
    #1 chk(tag, priv_rdata, exp);
    priv_rd = 1'b0; priv_lvl = 2'd1;
    #1;
  endtask

  task automatic ureq(logic [5:0] sel, logic wr, logic [63:0] cnt,
                      logic exp_pass, string tag);
    logic [63:0] wd;
    wd = 64'hC0DE_0000_0000_0000 | 64'(sel);
    usr_sel = sel; usr_write = wr; usr_wdata = wd; cnt_rdata = cnt;
    usr_valid = 1'b1;
    #1;
    chk({tag, " pass (R8 same cycle)"}, 64'(usr_pass), 64'(exp_pass));
    chk({tag, " fwd_wr"}, 64'(fwd_wr), 64'(exp_pass && wr));
    chk({tag, " fwd_wdata"}, fwd_wdata, (exp_pass && wr) ? wd : 64'd0);
    @(negedge clk);
    usr_valid = 1'b0; cnt_rdata = 64'hDEAD_DEAD_DEAD_DEAD;
    chk({tag, " rsp_valid R8"}, 64'(rsp_valid), 64'd1);
    chk({tag, " rsp_rdata"}, rsp_rdata, (exp_pass && !wr) ? cnt : 64'd0);
    @(negedge clk);
    chk({tag, " rsp_valid drop R8"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset();
    pread(2'd1, 64'd0, "R1 flags clear after reset");
    chk("R8 rsp_valid idle after reset", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_regfile();
    pwrite(2'd1, '1);
    pread(2'd2, 64'h0000_0001_80FF_FFFF, "R2 masked all-ones");
    pwrite(2'd3, 64'hFFFF_FFFE_0000_0005);
    pread(2'd1, 64'h0000_0000_0000_0005, "R2 sparse store");
  endtask

  task automatic t_user_level();
    pwrite(2'd0, '1);
    pread(2'd1, 64'h5, "R6 level0 write ignored");
    pread(2'd0, 64'd0, "R6 level0 read zero");
    priv_lvl = 2'd0; priv_rd = 1'b1;
    #1 chk("R6 undef on read", 64'(priv_undef), 64'd1);
    priv_rd = 1'b0; priv_lvl = 2'd1;
    #1;
  endtask

  task automatic t_deny();
    user_qual = 1'b1;
    ureq(6'd1, 1'b0, 64'h0000_ABCD, 1'b0, "R3 denied read");
    ureq(6'd1, 1'b1, 64'h0, 1'b0, "R3 denied write");
  endtask

  task automatic t_allow();
    user_qual = 1'b1;
    ureq(6'd2, 1'b0, 64'h1234_5678_9ABC, 1'b1, "R4 allowed read");
    ureq(6'd0, 1'b1, 64'h0, 1'b1, "R4 allowed write");
  endtask

  task automatic t_qual_off();
    user_qual = 1'b0;
    ureq(6'd1, 1'b0, 64'h7777, 1'b1, "R5 qual low read");
    ureq(6'd32, 1'b1, 64'h0, 1'b1, "R5 qual low fixed write");
    user_qual = 1'b1;
  endtask

  task automatic t_absent();
    pwrite(2'd1, '1);
    user_qual = 1'b0;
    ureq(6'd25, 1'b0, 64'h55, 1'b0, "R7 unimplemented qual low");
    ureq(6'd40, 1'b0, 64'h66, 1'b0, "R7 nonexistent qual low");
    user_qual = 1'b1;
    ureq(6'd25, 1'b1, 64'h0, 1'b0, "R7 unimplemented qual high");
    ureq(6'd23, 1'b0, 64'h99, 1'b1, "R7 last implemented passes");
  endtask

  task automatic t_cyc_fix();
    user_qual = 1'b1;
    pwrite(2'd1, 64'h0000_0000_8000_0000);
    ureq(6'd31, 1'b0, 64'hC1C1, 1'b1, "R9 cycle via bit31");
    ureq(6'd32, 1'b0, 64'hF1F1, 1'b0, "R9 fixed blocked");
    ureq(6'd0, 1'b0, 64'h1, 1'b0, "R9 event0 blocked");
    pwrite(2'd1, 64'h0000_0001_0000_0000);
    ureq(6'd32, 1'b0, 64'hF2F2, 1'b1, "R9 fixed via bit32");
    ureq(6'd31, 1'b0, 64'hC2C2, 1'b0, "R9 cycle blocked");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regfile();
    t_user_level();
    t_deny();
    t_allow();
    t_qual_off();
    t_absent();
    t_cyc_fix();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule